// File: doc/BRIEF.md
# Configurable Logic Macrocell with Selectable Register

This block is one macrocell of a programmable sum-of-products array. It receives already-formed product terms from the array. It ORs any chosen subset of them, plus an optional sum passed in from the neighbouring cell, into a sum term. That sum is combined through an XOR stage with a constant or with one product term, so the polarity can be set or arithmetic functions can be built. The result, a dedicated product term, or the pin value feeds a storage element. That element is configured as a D, T, JK or SR flip-flop or as a transparent latch.

The clock, clock enable, asynchronous clear and asynchronous preset each come from their own source selection, drawn from the global signals and the local product terms. The pin output and the buried feedback each choose, independently, the registered or the combinational value. The pin output enable has its own source select. The cell also drives an inverted copy of one product term for sharing across its region, and passes its sum onward for cascading. A static configuration word is captured while the power-on reset input is low and held from then on.

Top module: `lmc_macrocell`

## Requirements
- R1: The sum is the OR of every `pt_i[i]` whose `sum_mask` bit i is 1, ORed with `casc_i` when `casc_en` is 1. `casc_o` carries that sum.
- R2: The combinational value is the sum XOR a second operand chosen by `xor_sel`: 0 gives constant 0, 1 gives constant 1, 2 gives `pt_i[xor_idx]`.
- R3: `fold_o` is always the inverse of `pt_i[fold_idx]`.
- R4: The register data input is chosen by `din_sel`: 0 selects the combinational value, 1 selects `pt_i[dat_idx]`, 2 selects `pin_i`.
- R5: In `mode` 0 (D) the register loads the data on the rising edge of the selected clock. In `mode` 1 (T) it inverts when the data is 1 and holds otherwise.
- R6: The second input is `pt_i[aux_idx]`. In `mode` 2 (JK, J = data, K = second input) the register holds on 00, clears on 01, sets on 10 and toggles on 11. In `mode` 3 (SR, S = data, R = second input) it sets on 10, clears on 01, and holds on 00 and on 11.
- R7: In `mode` 4 (latch) the stored value follows the data while the selected clock is high and holds while it is low.
- R8: `clk_sel` 0, 1 or 2 picks `gclk_i[0]`, `gclk_i[1]` or `gclk_i[2]`, and 3 picks `pt_i[clk_idx]`. Edges on unselected clocks do not change the register.
- R9: With a global clock selected and `ce_en` 1, edges are ignored while `pt_i[ce_idx]` is 0. With the product-term clock selected, `ce_en` has no effect.
- R10: `ar_sel` picks the asynchronous clear: 0 none, 1 `gclr_i`, 2 `pt_i[ar_idx]`, 3 the OR of both. The clear forces the register to 0 and wins over the preset.
- R11: With `ap_en` 1, `pt_i[ap_idx]` asynchronously forces the register to 1. With `ap_en` 0 that term has no effect.
- R12: `pin_reg` 1 drives the register onto `pin_o` and 0 drives the combinational value. `fb_reg` makes the same choice for `fb_o`, independently.
- R13: `oe_sel` drives `pin_oe_o`: 0 gives 0, 1 gives 1, 2 gives `goe_i`, 3 gives the inverse of `goe_i`, 4 gives `pt_i[oe_idx]`.
- R14: While `por_n` is 0 the register is cleared and `cfg_i` is captured. Changes on `cfg_i` while `por_n` is 1 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| por_n | input | 1 | Power-on reset, active low; captures the configuration and clears the register |
| cfg_i | input | CFG_W (51) | Packed configuration word (`mc_cfg_t`) |
| pt_i | input | NUM_PT (5) | Product terms from the array |
| casc_i | input | 1 | Sum passed in from the neighbouring cell |
| gclk_i | input | NUM_GCLK (3) | Global clocks |
| gclr_i | input | 1 | Global asynchronous clear |
| goe_i | input | 1 | Global output enable |
| pin_i | input | 1 | Value read back from the pin |
| pin_o | output | 1 | Pin output value |
| pin_oe_o | output | 1 | Pin output enable |
| fb_o | output | 1 | Buried feedback to the global bus |
| fold_o | output | 1 | Inverted product term shared in the region |
| casc_o | output | 1 | Sum passed to the next cell |

## Verification
The sum and XOR path is swept over every product-term pattern, every enable mask, both cascade states and all three XOR operands. This separates a wrong mask bit, a missing cascade term and a swapped polarity constant. Each storage mode is driven with input sequences that reach every J/K and S/R combination and repeated toggles, so hold, toggle and set-clear confusions each give a distinct wrong value. Clock, enable, clear and preset sources are tried with stimulus on both the selected and the unselected sources, which shows whether a source is ignored when it should be. Clear is applied together with preset to test which one wins.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

   localparam int PT_CNT   = 5;
   localparam int GCLK_CNT = 3;
   localparam int IDX_W    = $clog2(PT_CNT);

   typedef logic [IDX_W-1:0] pt_idx_t;

   typedef enum logic [1:0] {XP_ZERO = 2'd0, XP_ONE = 2'd1, XP_PT = 2'd2} xor_sel_e;
   typedef enum logic [1:0] {DS_XOR = 2'd0, DS_PT = 2'd1, DS_PIN = 2'd2} din_sel_e;
   typedef enum logic [2:0] {RM_D = 3'd0, RM_T = 3'd1, RM_JK = 3'd2, RM_SR = 3'd3,
                             RM_LATCH = 3'd4} reg_mode_e;
   typedef enum logic [1:0] {CK_G0 = 2'd0, CK_G1 = 2'd1, CK_G2 = 2'd2, CK_PT = 2'd3} clk_sel_e;
   typedef enum logic [1:0] {AR_OFF = 2'd0, AR_GCLR = 2'd1, AR_PT = 2'd2, AR_BOTH = 2'd3} ar_sel_e;
   typedef enum logic [2:0] {OE_OFF = 3'd0, OE_ON = 3'd1, OE_GOE = 3'd2, OE_GOE_N = 3'd3,
                             OE_PT = 3'd4} oe_sel_e;

   typedef struct packed {
      logic [PT_CNT-1:0] sum_mask;
      logic              casc_en;
      xor_sel_e          xor_sel;
      pt_idx_t           xor_idx;
      din_sel_e          din_sel;
      pt_idx_t           dat_idx;
      reg_mode_e         mode;
      pt_idx_t           aux_idx;
      clk_sel_e          clk_sel;
      pt_idx_t           clk_idx;
      logic              ce_en;
      pt_idx_t           ce_idx;
      ar_sel_e           ar_sel;
      pt_idx_t           ar_idx;
      logic              ap_en;
      pt_idx_t           ap_idx;
      logic              pin_reg;
      logic              fb_reg;
      oe_sel_e           oe_sel;
      pt_idx_t           oe_idx;
      pt_idx_t           fold_idx;
   } mc_cfg_t;

   localparam int CFG_W = $bits(mc_cfg_t);

   // Product-term pick; an index past the last term reads as 0.
   function automatic logic pick(input logic [PT_CNT-1:0] v, input pt_idx_t i);
      return (int'(i) < PT_CNT) ? v[i] : 1'b0;
   endfunction

endpackage

// File: rtl/lmc_sum_xor.sv
module lmc_sum_xor
   import lmc_pkg::*;
#(
   parameter int NUM_PT      = PT_CNT,
   parameter bit HAS_CASCADE = 1'b1
) (
   input  logic [NUM_PT-1:0] pt_i,
   input  logic              casc_i,
   input  logic [NUM_PT-1:0] sum_mask_i,
   input  logic              casc_en_i,
   input  xor_sel_e          xor_sel_i,
   input  pt_idx_t           xor_idx_i,
   input  pt_idx_t           fold_idx_i,
   output logic              sum_o,
   output logic              xor_o,
   output logic              fold_o
);

   logic local_sum;
   logic xor_b;

   assign local_sum = |(pt_i & sum_mask_i);

   generate
      if (HAS_CASCADE) begin : g_casc
         assign sum_o = local_sum | (casc_en_i & casc_i);
      end else begin : g_no_casc
         logic unused_casc;
         assign unused_casc = casc_i ^ casc_en_i;
         assign sum_o       = local_sum;
      end
   endgenerate

   always_comb begin
      unique case (xor_sel_i)
         XP_ONE:  xor_b = 1'b1;
         XP_PT:   xor_b = pick(pt_i, xor_idx_i);
         default: xor_b = 1'b0;
      endcase
   end

   assign xor_o  = sum_o ^ xor_b;
   assign fold_o = ~pick(pt_i, fold_idx_i);

endmodule

// File: rtl/lmc_ctrl_sel.sv
module lmc_ctrl_sel
   import lmc_pkg::*;
#(
   parameter int NUM_PT   = PT_CNT,
   parameter int NUM_GCLK = GCLK_CNT
) (
   input  logic [NUM_PT-1:0]   pt_i,
   input  logic [NUM_GCLK-1:0] gclk_i,
   input  logic                gclr_i,
   input  logic                por_n,
   input  clk_sel_e            clk_sel_i,
   input  pt_idx_t             clk_idx_i,
   input  logic                ce_en_i,
   input  pt_idx_t             ce_idx_i,
   input  ar_sel_e             ar_sel_i,
   input  pt_idx_t             ar_idx_i,
   input  logic                ap_en_i,
   input  pt_idx_t             ap_idx_i,
   output logic                clk_o,
   output logic                ce_o,
   output logic                ar_o,
   output logic                ap_o
);

   logic [NUM_GCLK-1:0] gck_hit;
   logic                use_pt_clk;
   logic                ar_src;

   generate
      for (genvar g = 0; g < NUM_GCLK; g++) begin : g_gck
         assign gck_hit[g] = (int'(clk_sel_i) == g) & gclk_i[g];
      end
   endgenerate

   assign use_pt_clk = (clk_sel_i == CK_PT);
   assign clk_o      = (|gck_hit) | (use_pt_clk & pick(pt_i, clk_idx_i));

   // Enable only gates global clocks.
   assign ce_o = (!use_pt_clk && ce_en_i) ? pick(pt_i, ce_idx_i) : 1'b1;

   always_comb begin
      unique case (ar_sel_i)
         AR_GCLR: ar_src = gclr_i;
         AR_PT:   ar_src = pick(pt_i, ar_idx_i);
         AR_BOTH: ar_src = gclr_i | pick(pt_i, ar_idx_i);
         default: ar_src = 1'b0;
      endcase
   end

   assign ar_o = ar_src | ~por_n;
   assign ap_o = ap_en_i & pick(pt_i, ap_idx_i);

endmodule

// File: rtl/lmc_store.sv
module lmc_store
   import lmc_pkg::*;
(
   input  logic      clk_i,
   input  logic      ce_i,
   input  logic      ar_i,
   input  logic      ap_i,
   input  reg_mode_e mode_i,
   input  logic      d_i,
   input  logic      aux_i,
   output logic      q_o
);

   logic edge_q;
   logic lat_q;
   logic nxt;

   always_comb begin
      unique case (mode_i)
         RM_T: nxt = edge_q ^ d_i;
         RM_JK: begin
            unique case ({d_i, aux_i})
               2'b01:   nxt = 1'b0;
               2'b10:   nxt = 1'b1;
               2'b11:   nxt = ~edge_q;
               default: nxt = edge_q;
            endcase
         end
         RM_SR: begin
            unique case ({d_i, aux_i})
               2'b01:   nxt = 1'b0;
               2'b10:   nxt = 1'b1;
               default: nxt = edge_q;
            endcase
         end
         default: nxt = d_i;
      endcase
   end

   always_ff @(posedge clk_i or posedge ar_i or posedge ap_i) begin
      if (ar_i)      edge_q <= 1'b0;
      else if (ap_i) edge_q <= 1'b1;
      else if (ce_i) edge_q <= nxt;
   end

   always_latch begin
      if (ar_i)                lat_q = 1'b0;
      else if (ap_i)           lat_q = 1'b1;
      else if (clk_i && ce_i)  lat_q = d_i;
   end

   assign q_o = (mode_i == RM_LATCH) ? lat_q : edge_q;

endmodule

// File: rtl/lmc_macrocell.sv
module lmc_macrocell
   import lmc_pkg::*;
#(
   parameter int NUM_PT      = PT_CNT,
   parameter int NUM_GCLK    = GCLK_CNT,
   parameter bit HAS_CASCADE = 1'b1,
   localparam int CW         = CFG_W
) (
   input  logic                por_n,
   input  logic [CW-1:0]       cfg_i,
   input  logic [NUM_PT-1:0]   pt_i,
   input  logic                casc_i,
   input  logic [NUM_GCLK-1:0] gclk_i,
   input  logic                gclr_i,
   input  logic                goe_i,
   input  logic                pin_i,
   output logic                pin_o,
   output logic                pin_oe_o,
   output logic                fb_o,
   output logic                fold_o,
   output logic                casc_o
);

   generate
      if (NUM_PT != PT_CNT) begin : g_bad_pt
         $error("NUM_PT must match the configuration layout");
      end
      if (NUM_GCLK != GCLK_CNT) begin : g_bad_gck
         $error("NUM_GCLK must match the clock select encoding");
      end
   endgenerate

   mc_cfg_t cfg_q;
   logic    comb_v, din, aux;
   logic    clk_s, ce_s, ar_s, ap_s;
   logic    reg_q;

   // Configuration is held open only during power-on reset.
   always_latch begin
      if (!por_n) cfg_q = mc_cfg_t'(cfg_i);
   end

   lmc_sum_xor #(.NUM_PT(NUM_PT), .HAS_CASCADE(HAS_CASCADE)) u_sum (
      .pt_i       (pt_i),
      .casc_i     (casc_i),
      .sum_mask_i (cfg_q.sum_mask),
      .casc_en_i  (cfg_q.casc_en),
      .xor_sel_i  (cfg_q.xor_sel),
      .xor_idx_i  (cfg_q.xor_idx),
      .fold_idx_i (cfg_q.fold_idx),
      .sum_o      (casc_o),
      .xor_o      (comb_v),
      .fold_o     (fold_o)
   );

   lmc_ctrl_sel #(.NUM_PT(NUM_PT), .NUM_GCLK(NUM_GCLK)) u_ctrl (
      .pt_i      (pt_i),
      .gclk_i    (gclk_i),
      .gclr_i    (gclr_i),
      .por_n     (por_n),
      .clk_sel_i (cfg_q.clk_sel),
      .clk_idx_i (cfg_q.clk_idx),
      .ce_en_i   (cfg_q.ce_en),
      .ce_idx_i  (cfg_q.ce_idx),
      .ar_sel_i  (cfg_q.ar_sel),
      .ar_idx_i  (cfg_q.ar_idx),
      .ap_en_i   (cfg_q.ap_en),
      .ap_idx_i  (cfg_q.ap_idx),
      .clk_o     (clk_s),
      .ce_o      (ce_s),
      .ar_o      (ar_s),
      .ap_o      (ap_s)
   );

   always_comb begin
      unique case (cfg_q.din_sel)
         DS_PT:   din = pick(pt_i, cfg_q.dat_idx);
         DS_PIN:  din = pin_i;
         default: din = comb_v;
      endcase
   end

   assign aux = pick(pt_i, cfg_q.aux_idx);

   lmc_store u_store (
      .clk_i  (clk_s),
      .ce_i   (ce_s),
      .ar_i   (ar_s),
      .ap_i   (ap_s),
      .mode_i (cfg_q.mode),
      .d_i    (din),
      .aux_i  (aux),
      .q_o    (reg_q)
   );

   assign pin_o = cfg_q.pin_reg ? reg_q : comb_v;
   assign fb_o  = cfg_q.fb_reg  ? reg_q : comb_v;

   always_comb begin
      unique case (cfg_q.oe_sel)
         OE_ON:    pin_oe_o = 1'b1;
         OE_GOE:   pin_oe_o = goe_i;
         OE_GOE_N: pin_oe_o = ~goe_i;
         OE_PT:    pin_oe_o = pick(pt_i, cfg_q.oe_idx);
         default:  pin_oe_o = 1'b0;
      endcase
   end

endmodule

// File: rtl/lmc_macrocell_chk.sv
module lmc_macrocell_chk
   import lmc_pkg::*;
(
   input logic              clk,
   input logic              por_n,
   input mc_cfg_t           cfg,
   input logic [PT_CNT-1:0] pt,
   input logic              gclr,
   input logic              q,
   input logic              oe,
   input logic              casc
);

   logic clr_on;
   assign clr_on = ((cfg.ar_sel == AR_GCLR || cfg.ar_sel == AR_BOTH) && gclr) ||
                   ((cfg.ar_sel == AR_PT   || cfg.ar_sel == AR_BOTH) && pick(pt, cfg.ar_idx));

   assert_sum_cover_R1: assert property (@(posedge clk) disable iff (!por_n)
      (|(pt & cfg.sum_mask)) |-> casc);

   assert_clear_wins_R10: assert property (@(posedge clk) disable iff (!por_n)
      clr_on |-> !q);

   assert_preset_R11: assert property (@(posedge clk) disable iff (!por_n)
      (cfg.ap_en && pick(pt, cfg.ap_idx) && !clr_on) |-> q);

   assert_oe_off_R13: assert property (@(posedge clk) disable iff (!por_n)
      (cfg.oe_sel == OE_OFF) |-> !oe);

   assert_oe_on_R13: assert property (@(posedge clk) disable iff (!por_n)
      (cfg.oe_sel == OE_ON) |-> oe);

   assert_sr_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
      (cfg.mode == RM_SR && cfg.clk_sel == CK_G0 && !cfg.ce_en && cfg.din_sel == DS_PT &&
       cfg.ar_sel == AR_OFF && !cfg.ap_en &&
       pick(pt, cfg.dat_idx) && pick(pt, cfg.aux_idx)) |=> $stable(q));

endmodule

bind lmc_macrocell lmc_macrocell_chk u_chk (
   .clk   (gclk_i[0]),
   .por_n (por_n),
   .cfg   (cfg_q),
   .pt    (pt_i),
   .gclr  (gclr_i),
   .q     (u_store.q_o),
   .oe    (pin_oe_o),
   .casc  (casc_o)
);

// File: tb/tb_lmc_macrocell.sv
`timescale 1ns/1ps
module tb_lmc_macrocell;
   import lmc_pkg::*;

   logic              clk = 1'b0;
   logic              por_n = 1'b0;
   logic [CFG_W-1:0]  cfg_i = '0;
   logic [PT_CNT-1:0] pt = '0;
   logic              casc_in = 1'b0;
   logic              g1 = 1'b0, g2 = 1'b0;
   logic              gclr = 1'b0, goe = 1'b0, pin_in = 1'b0;
   logic              pin_o, pin_oe_o, fb_o, fold_o, casc_o;
   int                n_chk = 0, n_fail = 0;
   logic              exp_q;

   always #4 clk = ~clk;

   lmc_macrocell dut (
      .por_n(por_n), .cfg_i(cfg_i), .pt_i(pt), .casc_i(casc_in),
      .gclk_i({g2, g1, clk}), .gclr_i(gclr), .goe_i(goe), .pin_i(pin_in),
      .pin_o(pin_o), .pin_oe_o(pin_oe_o), .fb_o(fb_o), .fold_o(fold_o), .casc_o(casc_o)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   function automatic mc_cfg_t base();
      mc_cfg_t c;
      c = '0;
      c.xor_sel = XP_ZERO; c.din_sel = DS_XOR; c.mode = RM_D; c.clk_sel = CK_G0;
      c.ar_sel = AR_OFF; c.oe_sel = OE_ON; c.pin_reg = 1'b1; c.fb_reg = 1'b1;
      c.xor_idx = 3'd4; c.dat_idx = 3'd2; c.aux_idx = 3'd3; c.clk_idx = 3'd4;
      c.ce_idx = 3'd4; c.ar_idx = 3'd4; c.ap_idx = 3'd3; c.oe_idx = 3'd4; c.fold_idx = 3'd1;
      return c;
   endfunction

   task automatic apply(input mc_cfg_t c);
      @(negedge clk);
      por_n = 1'b0; cfg_i = c; pt = '0; gclr = 1'b0; g1 = 1'b0; g2 = 1'b0;
      pin_in = 1'b0; casc_in = 1'b0; goe = 1'b0;
      @(negedge clk);
      por_n = 1'b1;
      #1;
   endtask

   task automatic step();
      @(negedge clk);
      #1;
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
   endtask

   initial begin
      #(64'd8 * 64'd200000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      mc_cfg_t c;

      // R14: reset state
      apply(base());
      chk("R14 reset pin", pin_o, 1'b0);
      chk("R14 reset fb", fb_o, 1'b0);
      chk("R13 oe on", pin_oe_o, 1'b1);

      // R1 R2 R3 R12: sum / XOR sweep, combinational outputs
      for (int xs = 0; xs < 3; xs++) begin
         for (int ce = 0; ce < 2; ce++) begin
            for (int m = 0; m < 32; m++) begin
               c = base();
               c.pin_reg = 1'b0; c.fb_reg = 1'b0; c.sum_mask = 5'(m);
               c.casc_en = ce[0]; c.xor_sel = xor_sel_e'(xs);
               apply(c);
               for (int v = 0; v < 64; v++) begin
                  logic s, x;
                  pt = v[4:0]; casc_in = v[5];
                  #1;
                  s = (|(v[4:0] & m[4:0])) | (ce[0] & v[5]);
                  x = (xs == 0) ? 1'b0 : (xs == 1) ? 1'b1 : v[4];
                  chk("R1 casc_o", casc_o, s);
                  chk("R2 pin comb", pin_o, s ^ x);
                  chk("R12 fb comb", fb_o, s ^ x);
                  chk("R3 fold", fold_o, ~v[1]);
               end
            end
         end
      end

      // R4 R5: D mode for each data source
      for (int ds = 0; ds < 3; ds++) begin
         c = base(); c.din_sel = din_sel_e'(ds); c.sum_mask = 5'b00011; c.xor_sel = XP_ONE;
         apply(c);
         for (int i = 0; i < 12; i++) begin
            logic [5:0] v;
            logic d;
            v = 6'(i * 13 + 5);
            pt = v[4:0]; pin_in = v[5];
            d = (ds == 0) ? ~(v[0] | v[1]) : (ds == 1) ? v[2] : v[5];
            step();
            chk("R4 R5 D load", pin_o, d);
         end
      end

      // R5: T mode, data from pt[2]
      c = base(); c.mode = RM_T; c.din_sel = DS_PT; apply(c);
      exp_q = 1'b0;
      for (int i = 0; i < 8; i++) begin
         logic t;
         t = (8'b1011_0110 >> i) & 1'b1;
         pt[2] = t; exp_q = exp_q ^ t;
         step();
         chk("R5 T toggle", pin_o, exp_q);
      end

      // R6: JK mode, J=pt[2] K=pt[3]
      c = base(); c.mode = RM_JK; c.din_sel = DS_PT; apply(c);
      exp_q = 1'b0;
      for (int i = 0; i < 8; i++) begin
         logic [1:0] jk;
         jk = 2'((16'b10_00_11_11_01_00_11_01 >> (2 * (7 - i))) & 16'h3);
         pt[2] = jk[1]; pt[3] = jk[0];
         case (jk)
            2'b01: exp_q = 1'b0;
            2'b10: exp_q = 1'b1;
            2'b11: exp_q = ~exp_q;
            default: ;
         endcase
         step();
         chk("R6 JK", pin_o, exp_q);
      end

      // R6: SR mode, S=pt[2] R=pt[3], 11 holds
      c = base(); c.mode = RM_SR; c.din_sel = DS_PT; apply(c);
      exp_q = 1'b0;
      for (int i = 0; i < 8; i++) begin
         logic [1:0] sr;
         sr = 2'((16'b10_00_11_01_11_10_11_01 >> (2 * (7 - i))) & 16'h3);
         pt[2] = sr[1]; pt[3] = sr[0];
         if (sr == 2'b10) exp_q = 1'b1;
         else if (sr == 2'b01) exp_q = 1'b0;
         step();
         chk("R6 SR", pin_o, exp_q);
      end

      // R7: latch on product-term clock pt[4]
      c = base(); c.mode = RM_LATCH; c.din_sel = DS_PT; c.clk_sel = CK_PT; apply(c);
      pt[4] = 1'b1; pt[2] = 1'b1; #1; chk("R7 latch open", pin_o, 1'b1);
      pt[2] = 1'b0; #1; chk("R7 latch follow", pin_o, 1'b0);
      pt[2] = 1'b1; #1; chk("R7 latch follow", pin_o, 1'b1);
      pt[4] = 1'b0; #1; pt[2] = 1'b0; #1; chk("R7 latch hold", pin_o, 1'b1);
      step(); chk("R7 latch hold across g0", pin_o, 1'b1);
      pt[4] = 1'b1; #1; chk("R7 latch reopen", pin_o, 1'b0);

      // R8: clock source select
      for (int g = 1; g < 3; g++) begin
         c = base(); c.din_sel = DS_PT; c.clk_sel = clk_sel_e'(g); apply(c);
         pt[2] = 1'b1; step(); step();
         chk("R8 unselected g0 ignored", pin_o, 1'b0);
         if (g == 1) begin g1 = 1'b1; #1; g1 = 1'b0; end
         else begin g2 = 1'b1; #1; g2 = 1'b0; end
         #1; chk("R8 selected global edge", pin_o, 1'b1);
      end
      c = base(); c.din_sel = DS_PT; c.clk_sel = CK_PT; apply(c);
      pt[2] = 1'b1; step(); chk("R8 pt clock g0 ignored", pin_o, 1'b0);
      pt[4] = 1'b1; #1; chk("R8 pt clock edge", pin_o, 1'b1);

      // R9: clock enable
      c = base(); c.din_sel = DS_PT; c.ce_en = 1'b1; apply(c);
      pt[2] = 1'b1; step(); chk("R9 enable low holds", pin_o, 1'b0);
      pt[4] = 1'b1; step(); chk("R9 enable high loads", pin_o, 1'b1);
      pt[2] = 1'b0; pt[4] = 1'b0; step(); chk("R9 enable low holds 1", pin_o, 1'b1);
      c.clk_sel = CK_PT; c.clk_idx = 3'd0; apply(c);
      pt[2] = 1'b1; #1; pt[0] = 1'b1; #1;
      chk("R9 enable ignored on pt clock", pin_o, 1'b1);

      // R10 R11: asynchronous clear and preset
      c = base(); c.din_sel = DS_PT; c.ar_sel = AR_GCLR; c.ap_en = 1'b1; apply(c);
      pt[2] = 1'b1; step(); chk("R10 load before clear", pin_o, 1'b1);
      gclr = 1'b1; #1; chk("R10 gclr clears", pin_o, 1'b0);
      step(); chk("R10 clear holds over edge", pin_o, 1'b0);
      gclr = 1'b0; step(); chk("R10 release", pin_o, 1'b1);
      pt[2] = 1'b0; step(); chk("R11 data 0", pin_o, 1'b0);
      pt[3] = 1'b1; #1; chk("R11 preset sets", pin_o, 1'b1);
      step(); chk("R11 preset holds", pin_o, 1'b1);
      gclr = 1'b1; #1; chk("R10 clear beats preset", pin_o, 1'b0);
      pt[3] = 1'b0; #1; gclr = 1'b0; step();

      c.ap_en = 1'b0; c.ar_sel = AR_PT; apply(c);
      pt[2] = 1'b1; step();
      gclr = 1'b1; #1; chk("R10 gclr ignored in pt mode", pin_o, 1'b1);
      gclr = 1'b0; pt[4] = 1'b1; #1; chk("R10 pt clear", pin_o, 1'b0);
      pt[4] = 1'b0; step();
      pt[3] = 1'b1; #1; chk("R11 preset disabled", pin_o, 1'b1);
      pt[2] = 1'b0; step(); chk("R11 preset disabled no force", pin_o, 1'b0);
      pt[3] = 1'b0;

      c.ar_sel = AR_BOTH; apply(c);
      pt[2] = 1'b1; step();
      gclr = 1'b1; #1; chk("R10 both via gclr", pin_o, 1'b0);
      gclr = 1'b0; step(); chk("R10 both release", pin_o, 1'b1);
      pt[4] = 1'b1; #1; chk("R10 both via pt", pin_o, 1'b0);
      pt[4] = 1'b0; step();

      c.ar_sel = AR_OFF; apply(c);
      pt[2] = 1'b1; step();
      gclr = 1'b1; pt[4] = 1'b1; #1; chk("R10 off ignores both", pin_o, 1'b1);
      gclr = 1'b0; pt[4] = 1'b0;

      // R12: independent pin / feedback selection
      c = base(); c.sum_mask = 5'b00001; c.pin_reg = 1'b0; c.fb_reg = 1'b1; apply(c);
      pt[0] = 1'b1; #1;
      chk("R12 pin comb", pin_o, 1'b1); chk("R12 fb reg before edge", fb_o, 1'b0);
      step(); chk("R12 fb reg after edge", fb_o, 1'b1);
      c.pin_reg = 1'b1; c.fb_reg = 1'b0; apply(c);
      pt[0] = 1'b1; #1;
      chk("R12 fb comb", fb_o, 1'b1); chk("R12 pin reg before edge", pin_o, 1'b0);

      // R13: output enable sources
      for (int o = 0; o < 5; o++) begin
         c = base(); c.oe_sel = oe_sel_e'(o); apply(c);
         for (int v = 0; v < 4; v++) begin
            logic e;
            goe = v[0]; pt[4] = v[1]; #1;
            e = (o == 0) ? 1'b0 : (o == 1) ? 1'b1 : (o == 2) ? v[0] : (o == 3) ? ~v[0] : v[1];
            chk("R13 oe", pin_oe_o, e);
         end
      end

      // R14: configuration static after reset, por clears register
      c = base(); c.din_sel = DS_PT; apply(c);
      c.oe_sel = OE_OFF; c.pin_reg = 1'b0; cfg_i = c;
      pt[2] = 1'b1; step();
      chk("R14 cfg change ignored oe", pin_oe_o, 1'b1);
      chk("R14 cfg change ignored pin sel", pin_o, 1'b1);
      cfg_i = base(); por_n = 1'b0; #1;
      chk("R14 por clears", fb_o, 1'b0);
      por_n = 1'b1;

      summary();
      $finish;
   end

endmodule